// File: doc/BRIEF.md
# Wishbone to CSR Bus Bridge

This block is a Wishbone target that serves a narrow register bus. Each Wishbone access, read or write, is broken into a fixed run of narrow CSR-bus accesses, one for each chunk of the wide word. The chunks are issued at consecutive register-bus addresses, least significant chunk first. Reads gather the returned chunks into the wide data word. Writes slice the wide word into chunks, so the last narrow write is the one that commits the register.

Address translation is dense. The register-bus address is the Wishbone word address with the chunk index appended below it. A register-bus address space of `CSR_AW` bits therefore appears as a Wishbone space of `CSR_AW - log2(ratio)` bits.

Every access costs exactly `ratio + 1` cycles. The byte selects are not used to shorten it. The acknowledge falls in the same cycle as the write side effect of a register target that applies writes one cycle after its write strobe.

Top module: `wb_csr_bridge`

## Requirements
- R1: `CSR_DW` must be 8, 16, 32 or 64, and `WB_DW` defaults to `CSR_DW`. `WB_DW / CSR_DW` (the ratio) must be a power of two. With a ratio of 1, `csr_addr` equals `wb_adr` and an access acknowledges in its second cycle.
- R2: `wb_ack` is first high in cycle `ratio + 1` of an access, counting the first cycle in which `wb_cyc` and `wb_stb` are both high as cycle 1. It is high for exactly one cycle.
- R3: In cycles 1 to ratio of an access, exactly one register-bus strobe is issued per cycle. In cycle k+1 the address is `{wb_adr, k}`, with the chunk index in the low log2(ratio) bits, so chunks go out in ascending order.
- R4: A write issues only `csr_w_stb`, with `csr_w_data` equal to `wb_dat_w[k*CSR_DW +: CSR_DW]` for chunk k. A read issues only `csr_r_stb`.
- R5: The `csr_r_data` value present in the cycle after chunk k's read strobe appears at `wb_dat_r[k*CSR_DW +: CSR_DW]` in the acknowledge cycle. `wb_dat_r` is zero whenever no read is being acknowledged.
- R6: The last write strobe of an access is in the cycle just before `wb_ack`. A register target that writes one cycle after its strobe therefore holds the full new value in the acknowledge cycle.
- R7: `wb_sel` has no effect: with any select value, the same number of strobes, cycles and data are produced.
- R8: If `wb_cyc` or `wb_stb` drops before the acknowledge, the access is abandoned. The next access starts again at chunk 0 and takes the full `ratio + 1` cycles.
- R9: If `wb_stb` stays high after an acknowledge, a new access starts in the following cycle at chunk 0, with no acknowledge in that cycle.
- R10: While `rst` is high, and whenever `wb_cyc` and `wb_stb` are not both high, no strobe and no acknowledge are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr | input | WB_AW | Wishbone word address |
| wb_dat_w | input | WB_DW | Wishbone write data |
| wb_dat_r | output | WB_DW | Wishbone read data, valid with the acknowledge of a read |
| wb_sel | input | WB_DW/8 | Byte selects, not used |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Access strobe |
| wb_we | input | 1 | Write enable |
| wb_ack | output | 1 | Single-cycle acknowledge |
| csr_addr | output | CSR_AW | Register-bus chunk address |
| csr_r_stb | output | 1 | Register-bus read strobe |
| csr_r_data | input | CSR_DW | Register-bus read data, one cycle after the read strobe |
| csr_w_stb | output | 1 | Register-bus write strobe |
| csr_w_data | output | CSR_DW | Register-bus write data |

## Verification
The strobes and the address are combinational from the counter, so the bench samples them one time unit after the falling edge of every cycle of an access. It expects chunk k in cycle k+1 and the acknowledge in cycle ratio+1, counting from the edge at which `wb_stb` was driven. The bench's register-bus model returns read data one edge after the strobe and commits writes one edge after the strobe, which places the last returned chunk and the committed top chunk exactly in the acknowledge cycle, where the bench compares them. For back-to-back and abandoned accesses, the bench counts cycles again from the restart and expects chunk 0 in the first one.

// File: rtl/wb_csr_bridge.sv
module wb_csr_bridge #(
  parameter int CSR_DW = 8,
  parameter int WB_DW  = CSR_DW,
  parameter int CSR_AW = 8,
  localparam int RATIO = WB_DW / CSR_DW,
  localparam int IDXW  = (RATIO > 1) ? $clog2(RATIO) : 0,
  localparam int WB_AW = CSR_AW - IDXW,
  localparam int SELW  = (WB_DW + 7) / 8,
  localparam int CNTW  = $clog2(RATIO + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WB_AW-1:0]  wb_adr,
  input  logic [WB_DW-1:0]  wb_dat_w,
  output logic [WB_DW-1:0]  wb_dat_r,
  input  logic [SELW-1:0]   wb_sel,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  output logic              wb_ack,
  output logic [CSR_AW-1:0] csr_addr,
  output logic              csr_r_stb,
  input  logic [CSR_DW-1:0] csr_r_data,
  output logic              csr_w_stb,
  output logic [CSR_DW-1:0] csr_w_data
);
  timeunit 1ns;
  timeprecision 1ps;

  if (!(CSR_DW == 8 || CSR_DW == 16 || CSR_DW == 32 || CSR_DW == 64) ||
      (WB_DW % CSR_DW) != 0 || (RATIO & (RATIO - 1)) != 0) begin : g_bad_width
    $error("wb_csr_bridge: unsupported CSR_DW/WB_DW combination (R1)");
  end

  logic [CNTW-1:0]  cnt;
  logic             req;
  logic             issue;
  logic             sel_unused;
  logic [WB_DW-1:0] word;

  assign req        = wb_cyc & wb_stb & ~rst;
  assign issue      = req && (cnt != CNTW'(RATIO));
  assign wb_ack     = req && (cnt == CNTW'(RATIO));
  assign csr_r_stb  = issue & ~wb_we;
  assign csr_w_stb  = issue & wb_we;
  assign wb_dat_r   = (wb_ack && !wb_we) ? word : '0;
  assign sel_unused = ^wb_sel;

  always_ff @(posedge clk) begin
    if (rst || !req || wb_ack) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  if (RATIO == 1) begin : g_single
    assign csr_addr   = wb_adr;
    assign csr_w_data = wb_dat_w;
    assign word       = csr_r_data;
  end else begin : g_multi
    logic [IDXW-1:0]              idx;
    logic [(RATIO-1)*CSR_DW-1:0]  held;

    assign idx        = cnt[IDXW-1:0];
    assign csr_addr   = {wb_adr, idx};
    assign csr_w_data = wb_dat_w[idx*CSR_DW +: CSR_DW];
    assign word       = {csr_r_data, held};

    always_ff @(posedge clk) begin
      for (int k = 0; k < RATIO - 1; k++) begin
        if (req && !wb_we && cnt == CNTW'(k + 1))
          held[k*CSR_DW +: CSR_DW] <= csr_r_data;
      end
    end

    assert_first_chunk_R8: assert property (@(posedge clk) disable iff (rst)
      ((csr_r_stb || csr_w_stb) && !$past(csr_r_stb || csr_w_stb))
        |-> csr_addr[IDXW-1:0] == '0);
  end

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(csr_r_stb && csr_w_stb));

  assert_chunk_order_R3: assert property (@(posedge clk) disable iff (rst)
    ((csr_r_stb || csr_w_stb) && $past(csr_r_stb || csr_w_stb))
      |-> csr_addr == CSR_AW'($past(csr_addr) + 1'b1));

  assert_ack_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(csr_r_stb || csr_w_stb));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !(wb_cyc && wb_stb) |-> (!csr_r_stb && !csr_w_stb && !wb_ack));

endmodule

// File: tb/test_wb_csr_bridge.sv
module test_wb_csr_bridge;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CDW = 8;
  localparam int WDW = 32;
  localparam int CAW = 8;
  localparam int R   = WDW / CDW;
  localparam int WAW = CAW - 2;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [WAW-1:0] wb_adr;
  logic [WDW-1:0] wb_dat_w, wb_dat_r;
  logic [3:0]     wb_sel;
  logic           wb_cyc, wb_stb, wb_we, wb_ack;
  logic [CAW-1:0] csr_addr;
  logic           csr_r_stb, csr_w_stb;
  logic [CDW-1:0] csr_r_data, csr_w_data;

  wb_csr_bridge #(.CSR_DW(CDW), .WB_DW(WDW), .CSR_AW(CAW)) i_wb_csr_bridge (
    .clk(clk), .rst(rst), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_sel(wb_sel), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_ack(wb_ack),
    .csr_addr(csr_addr), .csr_r_stb(csr_r_stb), .csr_r_data(csr_r_data),
    .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data));

  logic [3:0]  n_adr, n_addr;
  logic [15:0] n_dat_w, n_dat_r, n_r_data, n_w_data;
  logic [1:0]  n_sel;
  logic        n_cyc, n_stb, n_we, n_ack, n_r_stb, n_w_stb;

  wb_csr_bridge #(.CSR_DW(16), .CSR_AW(4)) i_wb_csr_bridge_narrow (
    .clk(clk), .rst(rst), .wb_adr(n_adr), .wb_dat_w(n_dat_w), .wb_dat_r(n_dat_r),
    .wb_sel(n_sel), .wb_cyc(n_cyc), .wb_stb(n_stb), .wb_we(n_we), .wb_ack(n_ack),
    .csr_addr(n_addr), .csr_r_stb(n_r_stb), .csr_r_data(n_r_data),
    .csr_w_stb(n_w_stb), .csr_w_data(n_w_data));

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
      csr_r_data <= '0;
    end else begin
      csr_r_data <= csr_r_stb ? mem[csr_addr] : '0;
      if (csr_w_stb) mem[csr_addr] <= csr_w_data;
    end
  end

  always @(posedge clk) n_r_data <= n_r_stb ? {n_addr, 12'h5C3} : 16'h0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [WAW-1:0] a);
    return {exp_mem[{a, 2'd3}], exp_mem[{a, 2'd2}], exp_mem[{a, 2'd1}], exp_mem[{a, 2'd0}]};
  endfunction

  int  last_cycles;
  int  last_k;
  bit  last_order_ok;

  task automatic access(input bit we, input logic [WAW-1:0] adr, input logic [31:0] d,
                        input logic [3:0] sel, input bit hold);
    int  cyc_n = 0;
    int  k = 0;
    bit  order_ok = 1'b1;
    bit  type_ok = 1'b1;
    bit  data_ok = 1'b1;
    @(negedge clk);
    wb_adr = adr; wb_dat_w = d; wb_sel = sel; wb_we = we; wb_cyc = 1'b1; wb_stb = 1'b1;
    forever begin
      #1;
      cyc_n++;
      if (csr_r_stb || csr_w_stb) begin
        if (csr_addr != {adr, 2'(k)}) order_ok = 1'b0;
        if (csr_r_stb == we || csr_w_stb != we) type_ok = 1'b0;
        if (we && csr_w_data != d[k*8 +: 8]) data_ok = 1'b0;
        k++;
      end
      if (wb_ack || cyc_n > 20) break;
      @(negedge clk);
    end
    check(cyc_n == R + 1, "R2 ack cycle", 64'(cyc_n), 64'(R + 1));
    check(order_ok && k == R, "R3 chunk order/count", 64'(k), 64'(R));
    check(type_ok && data_ok, "R4 strobe type and write data", {62'd0, type_ok, data_ok}, 64'd3);
    if (sel != 4'hF)
      check(cyc_n == R + 1 && k == R, "R7 select ignored", 64'(cyc_n), 64'(R + 1));
    if (!we) begin
      check(wb_dat_r == exp_word(adr), "R5 read assembly", 64'(wb_dat_r), 64'(exp_word(adr)));
    end else begin
      check(wb_dat_r == '0, "R5 dat_r zero on write ack", 64'(wb_dat_r), 64'd0);
      check(mem[{adr, 2'd3}] == d[31:24], "R6 commit at ack", 64'(mem[{adr, 2'd3}]), 64'(d[31:24]));
      for (int j = 0; j < 4; j++) exp_mem[{adr, 2'(j)}] = d[j*8 +: 8];
    end
    last_cycles = cyc_n; last_k = k; last_order_ok = order_ok;
    if (!hold) begin
      wb_cyc = 1'b0; wb_stb = 1'b0;
    end
  endtask

  // we, adr, data, sel
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 6'h05, 32'hA1B2C3D4, 4'hF},
    {1'b0, 6'h05, 32'h0,        4'hF},
    {1'b1, 6'h06, 32'h11223344, 4'h0},
    {1'b0, 6'h06, 32'h0,        4'h0},
    {1'b0, 6'h10, 32'h0,        4'h1},
    {1'b1, 6'h3F, 32'hDEADBEEF, 4'h4},
    {1'b0, 6'h3F, 32'h0,        4'hF},
    {1'b0, 6'h00, 32'h0,        4'hF}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_byte(i);
    wb_adr = '0; wb_dat_w = '0; wb_sel = '0; wb_cyc = 0; wb_stb = 0; wb_we = 0;
    n_adr = '0; n_dat_w = '0; n_sel = '0; n_cyc = 0; n_stb = 0; n_we = 0;

    // R10: strobe held during reset
    repeat (2) @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1;
    #1 check(!csr_r_stb && !csr_w_stb && !wb_ack, "R10 quiet in reset",
             {61'd0, csr_r_stb, csr_w_stb, wb_ack}, 64'd0);
    @(negedge clk);
    wb_cyc = 1'b0; wb_stb = 1'b0; rst = 1'b0;
    #1 check(!csr_r_stb && !csr_w_stb && !wb_ack && wb_dat_r == '0, "R10 idle outputs",
             {61'd0, csr_r_stb, csr_w_stb, wb_ack}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][42], VEC[v][41:36], VEC[v][35:4], VEC[v][3:0], 1'b0);
    end

    // R8: abandoned access, then a full one
    @(negedge clk);
    wb_adr = 6'h02; wb_we = 1'b0; wb_sel = 4'hF; wb_cyc = 1'b1; wb_stb = 1'b1;
    repeat (2) @(negedge clk);
    wb_stb = 1'b0;
    #1 check(!csr_r_stb && !wb_ack, "R8 strobes stop on abort", {62'd0, csr_r_stb, wb_ack}, 64'd0);
    wb_cyc = 1'b0;
    access(1'b0, 6'h02, 32'h0, 4'hF, 1'b0);
    check(last_cycles == R + 1 && last_order_ok, "R8 restart from chunk 0", 64'(last_cycles), 64'(R + 1));

    // R9: back-to-back with stb held
    access(1'b0, 6'h07, 32'h0, 4'hF, 1'b1);
    begin
      int c = 1;
      @(negedge clk);
      #1 check(!wb_ack && csr_r_stb && csr_addr == {6'h07, 2'd0}, "R9 new access starts",
               64'(csr_addr), 64'({6'h07, 2'd0}));
      while (!wb_ack && c < 20) begin
        @(negedge clk);
        #1 c++;
      end
      check(c == R + 1 && wb_dat_r == exp_word(6'h07), "R9 second access result",
            64'(wb_dat_r), 64'(exp_word(6'h07)));
      wb_cyc = 1'b0; wb_stb = 1'b0;
    end

    // R1: default wide width equals narrow width, ratio 1
    @(negedge clk);
    n_adr = 4'h9; n_we = 1'b0; n_cyc = 1'b1; n_stb = 1'b1;
    #1 check(n_r_stb && !n_ack && n_addr == 4'h9, "R1 ratio-1 address", 64'(n_addr), 64'h9);
    @(negedge clk);
    #1 check(n_ack && n_dat_r == 16'h95C3, "R1 ratio-1 read in two cycles", 64'(n_dat_r), 64'h95C3);
    n_stb = 1'b0; n_cyc = 1'b0;
    @(negedge clk);
    n_adr = 4'h3; n_we = 1'b1; n_dat_w = 16'h1234; n_cyc = 1'b1; n_stb = 1'b1;
    #1 check(n_w_stb && n_w_data == 16'h1234 && !n_ack, "R1 ratio-1 write data", 64'(n_w_data), 64'h1234);
    @(negedge clk);
    #1 check(n_ack && !n_w_stb, "R1 ratio-1 write ack", {62'd0, n_ack, n_w_stb}, 64'd2);
    n_stb = 1'b0; n_cyc = 1'b0;

    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule